// File: doc/BRIEF.md
# Gate-token to quad-bit expander

This block takes a serial stream of 2-bit gate tokens and turns each accepted token into a group of four canvas bits. It does no search or decompression. One fixed code word places ones at the outer two positions of a group. The complementary code word places ones at the inner two positions. Groups are written in arrival order to consecutive positions of a 12,000-bit canvas (1500 columns by 8 rows, stored linearly). The canvas is reached through a plain write port: a bit address, a 4-bit data word and a write enable.

A frame holds 3000 tokens, which is 6000 bits or 750 bytes of payload. A `frame_start` pulse opens a frame and sets the write address to zero. Tokens arrive through a valid/ready handshake, at most one per cycle. After the last token the block raises `frame_done` and stops accepting tokens until the next `frame_start`. An illegal code word still uses up its four canvas positions, writes zeros to them and sets a sticky error flag.

Top module: `gate_token_expander`

## Requirements
- R1: The write address `wr_addr` is the canvas bit address of the first of the four bits in `wr_data`. It is 0 for the first token after `frame_start` and grows by 4 for each accepted token.
- R2: Token 2'b10 writes `wr_data` = 4'b1001. Bit k of `wr_data` lands at canvas position `wr_addr`+k, so bits 0 and 3 are set.
- R3: Token 2'b01 writes `wr_data` = 4'b0110, so bits 1 and 2 are set.
- R4: Tokens 2'b00 and 2'b11 write 4'b0000 and set `tok_error`. The flag stays high until the next `frame_start`.
- R5: `frame_done` rises together with the write of the 3000th token of a frame. It stays high until the next `frame_start`.
- R6: `tok_ready` is high only while a frame is open and `frame_start` is low. A token offered while `tok_ready` is low is ignored and produces no write.
- R7: While reset is held and after it is released, `tok_ready`, `wr_en`, `frame_done` and `tok_error` are low. The block stays idle until a `frame_start`.
- R8: A `frame_start` in the middle of a frame restarts it. The address returns to 0 and `tok_error` and `frame_done` are cleared.
- R9: Each accepted token produces exactly one write in the cycle after acceptance, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens or restarts a frame |
| tok_valid | input | 1 | Token offered |
| tok_data | input | 2 | Token code word |
| tok_ready | output | 1 | Token accepted this cycle when high with tok_valid |
| wr_en | output | 1 | Canvas write strobe |
| wr_addr | output | 14 | Canvas bit address of wr_data bit 0 |
| wr_data | output | 4 | Expanded group, bit k at wr_addr+k |
| frame_done | output | 1 | Whole canvas has been written |
| tok_error | output | 1 | Sticky illegal-token flag |

## Verification
The bench aims at the last token of a frame. A counter that is off by one there would raise `frame_done` one token early or late, or would keep `tok_ready` high and write past address 11996. Tokens offered after completion and during `frame_start` check that a leaky handshake would show up as an unexpected write. A restart in the middle of a frame that had an illegal token catches a design that keeps the old address or a stale error flag. Random code words with gaps between tokens catch swapped patterns, which would give 4'b0110 for 2'b10, and writes that are delayed or merged.

// File: rtl/gte_pkg.sv
package gte_pkg;
  localparam int TOK_W   = 2;
  localparam int GROUP_W = 4;

  typedef logic [TOK_W-1:0]   tok_t;
  typedef logic [GROUP_W-1:0] group_t;

  localparam tok_t   CODE_OUTER = 2'b10;
  localparam tok_t   CODE_INNER = 2'b01;
  localparam group_t PAT_OUTER  = 4'b1001;
  localparam group_t PAT_INNER  = 4'b0110;

  // Whether group bit k is an outer position (first or last).
  function automatic logic is_outer(input int k);
    return (k == 0) || (k == GROUP_W - 1);
  endfunction
endpackage

// File: rtl/gte_token_decode.sv
module gte_token_decode
  import gte_pkg::*;
(
  input  tok_t   tok,
  output group_t pattern,
  output logic   illegal
);
  logic hit_outer;
  logic hit_inner;

  assign hit_outer = (tok == CODE_OUTER);
  assign hit_inner = (tok == CODE_INNER);
  assign illegal   = !(hit_outer || hit_inner);

  for (genvar k = 0; k < GROUP_W; k++) begin : g_bit
    if (is_outer(k)) begin : g_outer
      assign pattern[k] = hit_outer;
    end else begin : g_inner
      assign pattern[k] = hit_inner;
    end
  end
endmodule

// File: rtl/gte_frame_seq.sv
module gte_frame_seq #(
  parameter int TOKENS = 3000,
  parameter int CNT_W  = $clog2(TOKENS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             tok_valid,
  output logic             tok_ready,
  output logic             accept,
  output logic [CNT_W-1:0] idx,
  output logic             frame_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOKENS - 1);

  logic             run_q;
  logic [CNT_W-1:0] idx_q;
  logic             done_q;

  assign tok_ready  = run_q && !frame_start;
  assign accept     = tok_ready && tok_valid;
  assign idx        = idx_q;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (frame_start) begin
      run_q  <= 1'b1;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      if (idx_q == LAST) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    accept && idx_q != LAST |=> idx_q == CNT_W'($past(idx_q) + 1'b1)); // R1
  AST_DONE_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !tok_ready); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> idx_q == '0 && !done_q && run_q); // R8
endmodule

// File: rtl/gte_write_stage.sv
module gte_write_stage
  import gte_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              accept,
  input  logic [CNT_W-1:0]  idx,
  input  group_t            pattern,
  input  logic              illegal,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output group_t            wr_data,
  output logic              tok_error
);
  localparam int SHIFT = $clog2(GROUP_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      tok_error <= 1'b0;
    end else begin
      wr_en <= accept;
      if (accept) begin
        wr_addr <= ADDR_W'(idx) << SHIFT;
        wr_data <= pattern;
      end
      if (frame_start)
        tok_error <= 1'b0;
      else if (accept && illegal)
        tok_error <= 1'b1;
    end
  end

  AST_PATTERN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data == '0 || wr_data == PAT_OUTER || wr_data == PAT_INNER)); // R2
  AST_ERROR_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_error) |-> wr_en && wr_data == '0); // R4
  AST_WRITE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> wr_en); // R9
endmodule

// File: rtl/gate_token_expander.sv
module gate_token_expander
  import gte_pkg::*;
#(
  parameter int CANVAS_BITS = 12000,
  parameter int TOKENS      = CANVAS_BITS / GROUP_W,
  parameter int ADDR_W      = $clog2(CANVAS_BITS),
  parameter int CNT_W       = $clog2(TOKENS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              tok_valid,
  input  logic [1:0]        tok_data,
  output logic              tok_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [3:0]        wr_data,
  output logic              frame_done,
  output logic              tok_error
);
  logic             accept;
  logic [CNT_W-1:0] idx;
  group_t           pattern;
  logic             illegal;

  gte_token_decode u_decode (
    .tok     (tok_data),
    .pattern (pattern),
    .illegal (illegal)
  );

  gte_frame_seq #(.TOKENS(TOKENS), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .tok_valid   (tok_valid),
    .tok_ready   (tok_ready),
    .accept      (accept),
    .idx         (idx),
    .frame_done  (frame_done)
  );

  gte_write_stage #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_write (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .accept      (accept),
    .idx         (idx),
    .pattern     (pattern),
    .illegal     (illegal),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .tok_error   (tok_error)
  );

  AST_ADDR_IN_CANVAS: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> int'(wr_addr) <= CANVAS_BITS - GROUP_W); // R1
  AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    tok_valid && !tok_ready |=> !wr_en); // R6
endmodule

// File: tb/gate_token_expander_tb.sv
module gate_token_expander_tb;
  localparam int NTOK = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_data = 2'b00;
  logic        tok_ready;
  logic        wr_en;
  logic [13:0] wr_addr;
  logic [3:0]  wr_data;
  logic        frame_done;
  logic        tok_error;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  // reference model state
  bit      m_run = 0, m_done = 0, m_err = 0;
  int      m_idx = 0;
  bit      p_wr = 0;
  int      p_addr = 0;
  logic [3:0] p_data = '0;

  always #2 clk = ~clk;

  gate_token_expander u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .tok_valid(tok_valid),
    .tok_data(tok_data), .tok_ready(tok_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_done(frame_done), .tok_error(tok_error)
  );

  function automatic logic [3:0] exp_group(input logic [1:0] t);
    case (t)
      2'b10:   return 4'b1001;
      2'b01:   return 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string data_req(input logic [3:0] d);
    if (d == 4'b1001) return "R2";
    if (d == 4'b0110) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Monitor: compare outputs, then advance the model with the inputs seen now.
  always @(negedge clk) begin
    if (checking) begin
      chk("R6 ready", tok_ready, m_run && !frame_start);
      chk("R9 write strobe", wr_en, p_wr);
      if (p_wr && wr_en) begin
        chk("R1 address", wr_addr, p_addr);
        chk(data_req(p_data), wr_data, p_data);
      end
      chk("R5 done", frame_done, m_done);
      chk("R4 error", tok_error, m_err);
    end
    if (rst) begin
      m_run = 0; m_done = 0; m_err = 0; m_idx = 0; p_wr = 0;
    end else begin
      bit acc;
      acc = m_run && !frame_start && tok_valid;
      p_wr = acc;
      if (acc) begin
        p_addr = m_idx * 4;
        p_data = exp_group(tok_data);
      end
      if (frame_start) begin
        m_run = 1; m_done = 0; m_err = 0; m_idx = 0;
      end else if (acc) begin
        if (p_data == 4'b0000) m_err = 1;
        if (m_idx == NTOK - 1) begin m_run = 0; m_done = 1; end
        else m_idx++;
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic start_frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
  endtask

  task automatic send(input logic [1:0] t);
    tok_valid = 1'b1; tok_data = t;
    do @(negedge clk); while (!tok_ready);
    tick();
    tok_valid = 1'b0;
  endtask

  task automatic send_random(input int n, input int bad_rate);
    for (int i = 0; i < n; i++) begin
      logic [1:0] t;
      int gap;
      gap = $urandom_range(0, 2);
      repeat (gap) tick();
      if ($urandom_range(0, 99) < bad_rate) t = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11;
      else t = ($urandom_range(0, 1) == 0) ? 2'b10 : 2'b01;
      send(t);
    end
  endtask

  task automatic offer_while_idle(input int n);
    tok_valid = 1'b1; tok_data = 2'b10;
    repeat (n) tick();
    tok_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (4) tick();
    // R7: reset state, directed
    chk("R7 ready in reset", tok_ready, 0);
    chk("R7 write in reset", wr_en, 0);
    chk("R7 done in reset", frame_done, 0);
    chk("R7 error in reset", tok_error, 0);
    rst = 1'b0;
    tick();
    checking = 1'b1;
    // R7/R6: tokens before any frame are ignored
    offer_while_idle(5);
    // directed patterns R2, R3, R4
    start_frame();
    send(2'b10); send(2'b01); send(2'b00); send(2'b11);
    send_random(40, 10);
    // R8: restart mid-frame while error is set
    tok_valid = 1'b1; tok_data = 2'b01;
    start_frame();
    tok_valid = 1'b0;
    tick();
    chk("R8 error cleared", tok_error, 0);
    // full frame, back to back toward the end
    send_random(NTOK - 10, 5);
    for (int i = 0; i < 9; i++) send(2'b01);
    send(2'b10);                      // 3000th token, address 11996
    tick();
    chk("R5 done after last", frame_done, 1);
    chk("R6 ready low after last", tok_ready, 0);
    // R6: offers after completion are ignored
    offer_while_idle(8);
    // second full frame, illegal last token, back to back
    start_frame();
    for (int i = 0; i < NTOK - 1; i++) send(($urandom_range(0, 1) == 0) ? 2'b10 : 2'b01);
    send(2'b11);
    tick();
    chk("R4 error on last", tok_error, 1);
    chk("R5 done second frame", frame_done, 1);
    // R7: reset mid-state
    rst = 1'b1; tick(); tick();
    checking = 1'b0;
    chk("R7 done after reset", frame_done, 0);
    chk("R7 error after reset", tok_error, 0);
    chk("R7 ready after reset", tok_ready, 0);
    rst = 1'b0;
    repeat (3) tick();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule